// File: doc/BRIEF.md
# Audio Link Frame Deserializer

This block is the receive side of a codec attached to a frame-based serial audio link. The controller drives a frame marker line and a single serial data line, both changing on the rising edge of a shared bit clock, and the block samples them on the falling edge. A frame is 256 bits long. It starts with a 16-bit header of per-slot valid flags, followed by twelve 20-bit payload slots.

The block finds the start of each frame from the rising edge of the marker and collects the header and the first four payload slots. When the last bit of a frame has arrived, it produces parallel results: a register command (read or write, with address and write data) and left and right PCM samples. Each result comes with a one-cycle strobe, and each strobe is gated by the header flags. A lock output shows whether the frame marker is arriving at the regular 256-bit spacing.

Top module: `aud_link_rx`

## Requirements
- R1: The marker and data inputs are sampled only on the falling edge of `bclk`. Every register in the block updates on that edge. `rst_n` clears the block at once and is released after two falling edges.
- R2: A frame begins when a sample of `sync_in` is 1 and the previous sample was 0. The data bit sampled on the next falling edge is frame bit 0, and the frame ends with frame bit 255.
- R3: Frame bits 0 to 4 are, in order, the frame-valid flag and the valid flags of slots 1, 2, 3 and 4. Slot n (n = 1 to 12) occupies frame bits 16+20(n-1) to 35+20(n-1), most significant bit first. Slots 5 to 12 do not affect any output.
- R4: A write strobe `reg_wr_stb` is issued when slot 1 bit 19 is 0 and both slot 1 and slot 2 are flagged valid. It loads `reg_addr` from slot 1 bits 18:12 and `reg_wdata` from slot 2 bits 19:4.
- R5: A read strobe `reg_rd_stb` is issued when slot 1 is flagged valid and slot 1 bit 19 is 1. It loads `reg_addr` from slot 1 bits 18:12. The validity of slot 2 has no effect on it. Read and write strobes are never issued together.
- R6: `pcm_left_vld` is issued and `pcm_left` is loaded from slot 3 when slot 3 is flagged valid. `pcm_right_vld` and `pcm_right` follow slot 4 in the same way.
- R7: When the frame-valid flag is 0, no strobe is issued and no data output changes, whatever the slot flags hold.
- R8: Strobes and data outputs change only on the falling edge that samples frame bit 255, so they are visible from the next rising edge. Each strobe is high for exactly one cycle. Between strobes, `reg_addr`, `reg_wdata`, `pcm_left` and `pcm_right` hold their values.
- R9: `lock` rises on the falling edge that samples a marker rising edge, provided that edge does not cut a frame short. This happens at the first marker edge after reset or after a loss, and at every on-time marker edge.
- R10: If frame bit 255 is sampled without a marker rising edge in the same sample, `lock` falls on that edge. The completed frame still produces its results.
- R11: A marker rising edge that arrives before frame bit 255 clears `lock` and restarts the frame at bit 0. The cut-short frame produces no strobe.
- R12: During reset, all strobes, `lock` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; inputs sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame marker; a rising edge starts a frame |
| sdata_in | input | 1 | Serial frame data, most significant bit first |
| lock | output | 1 | Marker is recurring every 256 bits |
| reg_wr_stb | output | 1 | One-cycle register write command |
| reg_rd_stb | output | 1 | One-cycle register read command |
| reg_addr | output | ADDR_W | Register address of the last command |
| reg_wdata | output | CMD_DW | Write data of the last write command |
| pcm_left_vld | output | 1 | One-cycle strobe for a new left sample |
| pcm_left | output | SLOT_W | Last left PCM sample |
| pcm_right_vld | output | 1 | One-cycle strobe for a new right sample |
| pcm_right | output | SLOT_W | Last right PCM sample |

## Verification
Frame results are due at the first rising edge after the falling edge that samples frame bit 255. For each complete frame, the driver records that cycle together with the expected strobes and held data. The monitor counts falling edges and compares each strobe it sees against both the recorded cycle and the recorded values, so a strobe that comes early, comes late, lasts two cycles or should not exist is reported. Lock changes on the falling edge that samples the marker, or that samples bit 255. The bench checks it just after that same falling edge, without spending an extra bit slot of the stream.

// File: rtl/aud_link_rx_pkg.sv
package aud_link_rx_pkg;

  // number of payload slots whose contents reach the outputs
  localparam int unsigned CAPT_SLOTS = 4;

  // zero-based indices into the captured slot array
  localparam int unsigned IDX_CMD_ADR = 0;
  localparam int unsigned IDX_CMD_DAT = 1;
  localparam int unsigned IDX_PCM_L   = 2;
  localparam int unsigned IDX_PCM_R   = 3;

  // header flags kept: frame-valid plus one per captured slot
  localparam int unsigned TAG_KEEP = 1 + CAPT_SLOTS;

  typedef struct packed {
    logic wr;
    logic rd;
    logic lv;
    logic rv;
  } stb_t;

endpackage

// File: rtl/aud_link_rx_rst.sv
module aud_link_rx_rst (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/aud_link_rx_framer.sv
module aud_link_rx_framer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic             bit_vld,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_done,
  output logic             lock
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  logic             sync_q, sync_n;
  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             lock_q, lock_n;
  logic             rise, at_last;

  assign rise    = sync_in & ~sync_q;
  assign at_last = act_q && (cnt_q == LAST_IDX);

  always_comb begin
    sync_n = sync_in;
    act_n  = act_q;
    cnt_n  = cnt_q;
    lock_n = lock_q;
    if (rise) begin
      // restart alignment; early marker (frame not finished) drops lock
      act_n  = 1'b1;
      cnt_n  = '0;
      lock_n = !(act_q && !at_last);
    end else if (at_last) begin
      // frame complete with no marker: wait for the next one
      act_n  = 1'b0;
      cnt_n  = '0;
      lock_n = 1'b0;
    end else if (act_q) begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  assign bit_vld    = act_q;
  assign bit_idx    = cnt_q;
  assign frame_done = at_last;
  assign lock       = lock_q;

endmodule

// File: rtl/aud_link_rx_capture.sv
module aud_link_rx_capture
  import aud_link_rx_pkg::*;
#(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sdata_in,
  input  logic                                 bit_vld,
  input  logic [CNT_W-1:0]                     bit_idx,
  output logic [TAG_KEEP-1:0]                  tag,
  output logic [CAPT_SLOTS-1:0][SLOT_W-1:0]    slot_data
);

  localparam logic [CNT_W-1:0] TAG_END = CNT_W'(TAG_KEEP);

  logic [TAG_KEEP-1:0] tag_q, tag_n;

  always_comb begin
    tag_n = tag_q;
    if (bit_vld && (bit_idx < TAG_END)) tag_n = {tag_q[TAG_KEEP-2:0], sdata_in};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_n;
  end

  assign tag = tag_q;

  for (genvar s = 0; s < CAPT_SLOTS; s++) begin : g_slot
    localparam logic [CNT_W-1:0] LO = CNT_W'(TAG_W + s * SLOT_W);
    localparam logic [CNT_W-1:0] HI = CNT_W'(TAG_W + (s + 1) * SLOT_W - 1);

    logic [SLOT_W-1:0] sh_q, sh_n;
    logic              in_win;

    assign in_win = bit_vld && (bit_idx >= LO) && (bit_idx <= HI);

    always_comb begin
      sh_n = sh_q;
      if (in_win) sh_n = {sh_q[SLOT_W-2:0], sdata_in};
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_n;
    end

    assign slot_data[s] = sh_q;
  end

endmodule

// File: rtl/aud_link_rx_decode.sv
module aud_link_rx_decode
  import aud_link_rx_pkg::*;
#(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CMD_DW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frame_done,
  input  logic [TAG_KEEP-1:0]               tag,
  input  logic [CAPT_SLOTS-1:0][SLOT_W-1:0] slot_data,
  output stb_t                              stb,
  output logic [ADDR_W-1:0]                 reg_addr,
  output logic [CMD_DW-1:0]                 reg_wdata,
  output logic [SLOT_W-1:0]                 pcm_left,
  output logic [SLOT_W-1:0]                 pcm_right
);

  logic              fv, t_adr, t_dat, t_l, t_r;
  logic [SLOT_W-1:0] s_adr, s_dat;
  logic              is_read;

  stb_t              stb_q, stb_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CMD_DW-1:0] wd_q, wd_n;
  logic [SLOT_W-1:0] l_q, l_n, r_q, r_n;
  logic              unused_slot_bits;

  assign fv      = tag[TAG_KEEP-1];
  assign t_adr   = tag[TAG_KEEP-2-IDX_CMD_ADR];
  assign t_dat   = tag[TAG_KEEP-2-IDX_CMD_DAT];
  assign t_l     = tag[TAG_KEEP-2-IDX_PCM_L];
  assign t_r     = tag[TAG_KEEP-2-IDX_PCM_R];
  assign s_adr   = slot_data[IDX_CMD_ADR];
  assign s_dat   = slot_data[IDX_CMD_DAT];
  assign is_read = s_adr[SLOT_W-1];

  assign unused_slot_bits = ^{s_adr[SLOT_W-2-ADDR_W:0], s_dat[SLOT_W-1-CMD_DW:0]};

  always_comb begin
    stb_n.wr = frame_done & fv & t_adr & t_dat & ~is_read;
    stb_n.rd = frame_done & fv & t_adr & is_read;
    stb_n.lv = frame_done & fv & t_l;
    stb_n.rv = frame_done & fv & t_r;
    addr_n   = addr_q;
    wd_n     = wd_q;
    l_n      = l_q;
    r_n      = r_q;
    if (stb_n.wr || stb_n.rd) addr_n = s_adr[SLOT_W-2 -: ADDR_W];
    if (stb_n.wr)             wd_n   = s_dat[SLOT_W-1 -: CMD_DW];
    if (stb_n.lv)             l_n    = slot_data[IDX_PCM_L];
    if (stb_n.rv)             r_n    = slot_data[IDX_PCM_R];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      stb_q  <= stb_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      l_q    <= l_n;
      r_q    <= r_n;
    end
  end

  assign stb       = stb_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wd_q;
  assign pcm_left  = l_q;
  assign pcm_right = r_q;

endmodule

// File: rtl/aud_link_rx.sv
module aud_link_rx
  import aud_link_rx_pkg::*;
#(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned N_SLOTS = 12,
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned CMD_DW  = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              sdata_in,
  output logic              lock,
  output logic              reg_wr_stb,
  output logic              reg_rd_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [CMD_DW-1:0] reg_wdata,
  output logic              pcm_left_vld,
  output logic [SLOT_W-1:0] pcm_left,
  output logic              pcm_right_vld,
  output logic [SLOT_W-1:0] pcm_right
);

  localparam int unsigned FRAME_LEN = TAG_W + N_SLOTS * SLOT_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  logic                              core_rst_n;
  logic                              bit_vld;
  logic [CNT_W-1:0]                  bit_idx;
  logic                              frame_done;
  logic [TAG_KEEP-1:0]               tag;
  logic [CAPT_SLOTS-1:0][SLOT_W-1:0] slot_data;
  stb_t                              stb;

  aud_link_rx_rst u_rst (
    .clk     (bclk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  aud_link_rx_framer #(
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W)
  ) u_framer (
    .clk        (bclk),
    .rst_n      (core_rst_n),
    .sync_in    (sync_in),
    .bit_vld    (bit_vld),
    .bit_idx    (bit_idx),
    .frame_done (frame_done),
    .lock       (lock)
  );

  aud_link_rx_capture #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .CNT_W  (CNT_W)
  ) u_capture (
    .clk       (bclk),
    .rst_n     (core_rst_n),
    .sdata_in  (sdata_in),
    .bit_vld   (bit_vld),
    .bit_idx   (bit_idx),
    .tag       (tag),
    .slot_data (slot_data)
  );

  aud_link_rx_decode #(
    .SLOT_W (SLOT_W),
    .ADDR_W (ADDR_W),
    .CMD_DW (CMD_DW)
  ) u_decode (
    .clk        (bclk),
    .rst_n      (core_rst_n),
    .frame_done (frame_done),
    .tag        (tag),
    .slot_data  (slot_data),
    .stb        (stb),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pcm_left   (pcm_left),
    .pcm_right  (pcm_right)
  );

  assign reg_wr_stb    = stb.wr;
  assign reg_rd_stb    = stb.rd;
  assign pcm_left_vld  = stb.lv;
  assign pcm_right_vld = stb.rv;

endmodule

// File: rtl/aud_link_rx_chk.sv
module aud_link_rx_chk #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned ADDR_W = 7
) (
  input logic              bclk,
  input logic              rst_n,
  input logic              sync_in,
  input logic              lock,
  input logic              frame_done,
  input logic              reg_wr_stb,
  input logic              reg_rd_stb,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              pcm_left_vld,
  input logic [SLOT_W-1:0] pcm_left,
  input logic              pcm_right_vld
);

  logic any_stb;
  assign any_stb = reg_wr_stb | reg_rd_stb | pcm_left_vld | pcm_right_vld;

  assert_one_cycle_R8: assert property (@(negedge bclk) disable iff (!rst_n)
    any_stb |=> !any_stb);

  assert_only_at_end_R8: assert property (@(negedge bclk) disable iff (!rst_n)
    any_stb |-> $past(frame_done));

  assert_rw_exclusive_R5: assert property (@(negedge bclk) disable iff (!rst_n)
    !(reg_wr_stb && reg_rd_stb));

  assert_addr_hold_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    !(reg_wr_stb || reg_rd_stb) |-> $stable(reg_addr));

  assert_left_hold_R6: assert property (@(negedge bclk) disable iff (!rst_n)
    !pcm_left_vld |-> $stable(pcm_left));

  assert_lock_on_marker_R9: assert property (@(negedge bclk) disable iff (!rst_n)
    $rose(lock) |-> $past(sync_in));

endmodule

bind aud_link_rx aud_link_rx_chk #(
  .SLOT_W (SLOT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .bclk          (bclk),
  .rst_n         (rst_n),
  .sync_in       (sync_in),
  .lock          (lock),
  .frame_done    (frame_done),
  .reg_wr_stb    (reg_wr_stb),
  .reg_rd_stb    (reg_rd_stb),
  .reg_addr      (reg_addr),
  .pcm_left_vld  (pcm_left_vld),
  .pcm_left      (pcm_left),
  .pcm_right_vld (pcm_right_vld)
);

// File: tb/aud_link_rx_tb.sv
module aud_link_rx_tb;

  logic        bclk = 1'b0;
  logic        rst_n;
  logic        sync_in;
  logic        sdata_in;
  logic        lock;
  logic        reg_wr_stb;
  logic        reg_rd_stb;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        pcm_left_vld;
  logic [19:0] pcm_left;
  logic        pcm_right_vld;
  logic [19:0] pcm_right;

  always #5 bclk = ~bclk;

  aud_link_rx u_dut (
    .bclk          (bclk),
    .rst_n         (rst_n),
    .sync_in       (sync_in),
    .sdata_in      (sdata_in),
    .lock          (lock),
    .reg_wr_stb    (reg_wr_stb),
    .reg_rd_stb    (reg_rd_stb),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .pcm_left_vld  (pcm_left_vld),
    .pcm_left      (pcm_left),
    .pcm_right_vld (pcm_right_vld),
    .pcm_right     (pcm_right)
  );

  typedef struct {
    bit        wr, rd, lv, rv;
    bit [6:0]  addr;
    bit [15:0] wd;
    bit [19:0] l, r;
    int        due;
  } exp_t;

  exp_t      q[$];
  int        total = 0;
  int        bad   = 0;
  int        ncyc  = 0;
  bit [6:0]  m_addr = '0;
  bit [15:0] m_wd   = '0;
  bit [19:0] m_l    = '0;
  bit [19:0] m_r    = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge bclk) ncyc++;

  // monitor: every strobe must match the next expected item, in its cycle
  always @(posedge bclk) begin
    if (rst_n && (reg_wr_stb || reg_rd_stb || pcm_left_vld || pcm_right_vld)) begin
      if (q.size() == 0) begin
        check(0, "R7", "strobe with nothing expected",
              {reg_wr_stb, reg_rd_stb, pcm_left_vld, pcm_right_vld}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(ncyc == e.due, "R8", "result cycle", ncyc, e.due);
        check(reg_wr_stb == e.wr, "R4", "write strobe", reg_wr_stb, e.wr);
        check(reg_rd_stb == e.rd, "R5", "read strobe", reg_rd_stb, e.rd);
        check(pcm_left_vld == e.lv, "R6", "left strobe", pcm_left_vld, e.lv);
        check(pcm_right_vld == e.rv, "R6", "right strobe", pcm_right_vld, e.rv);
        check(reg_addr == e.addr, "R3", "address", reg_addr, e.addr);
        check(reg_wdata == e.wd, "R4", "write data", reg_wdata, e.wd);
        check(pcm_left == e.l, "R6", "left sample", pcm_left, e.l);
        check(pcm_right == e.r, "R6", "right sample", pcm_right, e.r);
      end
    end
  end

  function automatic bit [255:0] mk(input bit [15:0] tag, input bit [19:0] s1,
                                    input bit [19:0] s2, input bit [19:0] s3,
                                    input bit [19:0] s4, input bit [19:0] fill);
    bit [255:0] v;
    for (int i = 0; i < 16; i++) v[i] = tag[15-i];
    for (int s = 0; s < 12; s++) begin
      bit [19:0] val;
      case (s)
        0:       val = s1;
        1:       val = s2;
        2:       val = s3;
        3:       val = s4;
        default: val = fill ^ 20'(s * 20'h1111);
      endcase
      for (int j = 0; j < 20; j++) v[16 + 20*s + j] = val[19-j];
    end
    return v;
  endfunction

  function automatic bit [255:0] mksync(input bit next_edge);
    bit [255:0] v;
    v = '0;
    for (int i = 0; i < 15; i++) v[i] = 1'b1;
    v[255] = next_edge;
    return v;
  endfunction

  // reference model from R3..R7
  function automatic exp_t model(input bit [15:0] tag, input bit [19:0] s1,
                                 input bit [19:0] s2, input bit [19:0] s3,
                                 input bit [19:0] s4);
    exp_t e;
    bit   fv;
    fv   = tag[15];
    e.wr = fv & tag[14] & tag[13] & ~s1[19];
    e.rd = fv & tag[14] & s1[19];
    e.lv = fv & tag[12];
    e.rv = fv & tag[11];
    if (e.wr || e.rd) m_addr = s1[18:12];
    if (e.wr)         m_wd   = s2[19:4];
    if (e.lv)         m_l    = s3;
    if (e.rv)         m_r    = s4;
    e.addr = m_addr;
    e.wd   = m_wd;
    e.l    = m_l;
    e.r    = m_r;
    e.due  = 0;
    return e;
  endfunction

  task automatic drive(input bit s, input bit d);
    @(posedge bclk);
    sync_in  = s;
    sdata_in = d;
  endtask

  task automatic send(input bit [255:0] dat, input bit [255:0] syn, input int len,
                      input bit complete, input exp_t e);
    for (int i = 0; i < len; i++) drive(syn[i], dat[i]);
    if (complete && (e.wr || e.rd || e.lv || e.rv)) begin
      e.due = ncyc + 1;
      q.push_back(e);
    end
  endtask

  task automatic check_lock(input bit exp, input string req);
    @(negedge bclk);
    #1;
    check(lock == exp, req, "lock", lock, exp);
  endtask

  task automatic frame(input bit [15:0] tag, input bit [19:0] s1, input bit [19:0] s2,
                       input bit [19:0] s3, input bit [19:0] s4, input bit next_edge);
    exp_t e;
    e = model(tag, s1, s2, s3, s4);
    send(mk(tag, s1, s2, s3, s4, 20'h5A5A5), mksync(next_edge), 256, 1'b1, e);
  endtask

  initial begin
    #2_000_000;
    check(0, "WDOG", "watchdog expired", ncyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_t       dummy;
    bit [255:0] syn;
    dummy    = '{default: 0};
    rst_n    = 1'b1;
    sync_in  = 1'b0;
    sdata_in = 1'b0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge bclk);
    #1;
    // R12: reset state
    check(lock == 0, "R12", "lock in reset", lock, 0);
    check({reg_wr_stb, reg_rd_stb, pcm_left_vld, pcm_right_vld} == 0, "R12",
          "strobes in reset", {reg_wr_stb, reg_rd_stb, pcm_left_vld, pcm_right_vld}, 0);
    check({reg_addr, reg_wdata, pcm_left, pcm_right} == 0, "R12", "data in reset",
          {reg_addr, reg_wdata}, 0);
    @(posedge bclk);
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 1'b0);
    check(lock == 0, "R1", "lock idle after release", lock, 0);

    // R2, R9: first marker edge
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    check_lock(1'b1, "R9");

    // R4, R6: write with both samples
    frame(16'hF800, {1'b0, 7'h2A, 12'h000}, {16'hBEEF, 4'h0}, 20'h12345, 20'hABCDE, 1'b1);
    // R5: read, left only, slot 2 invalid
    frame(16'hD000, {1'b1, 7'h7F, 12'h000}, 20'h0, 20'h0F0F0, 20'h0, 1'b1);
    // R4: write lacking slot 2 flag -> no write; right only
    frame(16'hC800, {1'b0, 7'h11, 12'h000}, 20'h0, 20'h0, 20'h13579, 1'b1);
    // R7: frame-valid clear with every slot flagged
    frame(16'h7800, {1'b0, 7'h05, 12'h000}, {16'h1234, 4'h0}, 20'hFFFFF, 20'h55555, 1'b1);
    check_lock(1'b1, "R9");
    // R3: high address bit, slots 5..12 noise; R10: marker missing afterwards
    frame(16'hE000, {1'b0, 7'h40, 12'h000}, {16'h8001, 4'h0}, 20'h0, 20'h0, 1'b0);
    check_lock(1'b0, "R10");
    repeat (5) drive(1'b0, 1'b0);
    check(lock == 0, "R10", "lock stays low while idle", lock, 0);
    drive(1'b1, 1'b0);
    check_lock(1'b1, "R9");

    // R11: marker arrives at frame bit 100
    syn = mksync(1'b0);
    syn[100] = 1'b1;
    send(mk(16'hF800, {1'b0, 7'h66, 12'h000}, {16'hCAFE, 4'h0}, 20'h77777, 20'h88888,
            20'h0), syn, 101, 1'b0, dummy);
    check_lock(1'b0, "R11");
    // restarted frame is complete and delivered
    frame(16'hD800, {1'b1, 7'h33, 12'h000}, 20'h0, 20'h00001, 20'hFFFFF, 1'b1);
    check_lock(1'b1, "R9");
    // R7: frame valid but no slot flagged
    frame(16'h8000, {1'b1, 7'h01, 12'h000}, 20'h0, 20'h22222, 20'h33333, 1'b0);
    check_lock(1'b0, "R10");
    repeat (10) drive(1'b0, 1'b0);

    check(q.size() == 0, "R8", "results outstanding", q.size(), 0);
    check(reg_addr == m_addr, "R7", "held address", reg_addr, m_addr);
    check(reg_wdata == m_wd, "R7", "held write data", reg_wdata, m_wd);
    check(pcm_left == m_l, "R7", "held left", pcm_left, m_l);
    check(pcm_right == m_r, "R7", "held right", pcm_right, m_r);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule